// File: doc/BRIEF.md
# Watchdog and NMI Control Register

This block is a 16-bit control register that software programs through a simple write port and reads back through a read port that always reflects current state. It serves a system-management unit. It drives a halt line to a watchdog counter and a send request to a message engine, and it raises that request until the engine reports completion. It also provides a sticky lock that closes the write path to an external watchdog-enable bit.

The register also decides where non-maskable interrupt events go. With redirection off, incoming events pass to the NMI output as one-cycle pulses. With redirection on, they become one-cycle SMI pulses, but only when the NMI-disable input is low and the global SMI enable is high. Software can also force an NMI through a toggle bit. Writing one sets it and fires one pulse, and writing one again acknowledges it.

Top module: `wdt_nmi_ctl`

## Requirements
- R1: After synchronous reset, rdata is 0x0000, tmr_halt, send_req, nmi_out and smi_out are 0, and tmr_en_wr_ok is 1.
- R2: Bits 15:13 and 7:0 of rdata read 0 whatever is written to them.
- R3: Bit 12 (lock) is set by writing 1. Writing 0 leaves it at 1. Only reset clears it.
- R4: tmr_en_wr_ok is 0 while lock is 1 and 1 while lock is 0.
- R5: Bit 11 (halt) takes the written value on every write, and tmr_halt equals that bit.
- R6: Writing 1 to bit 10 (send) while it is 0 sets it, and send_req follows it.
- R7: send_done clears bit 10 in the next cycle and takes priority over a write in the same cycle. Writing 0, or writing 1 while the bit is set, leaves it unchanged.
- R8: Bit 9 (redirect) takes the written value on every write. While it is 0, an nmi_evt cycle gives an nmi_out pulse one cycle later and no smi_out.
- R9: While redirect is 1, an nmi_evt cycle gives an smi_out pulse one cycle later only if nmi_dis is 0 and gbl_smi_en is 1. It never gives nmi_out, and it gives nothing in any other case.
- R10: Writing 1 to bit 8 (forced NMI) while it is 0 sets it and gives one nmi_out pulse in the next cycle. Writing 1 while it is 1 clears it without a pulse. Writing 0 has no effect.
- R11: rdata shows all implemented bits together at once, one cycle after the write that changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high core reset |
| wr_en | input | 1 | Write strobe for the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Current register image |
| send_done | input | 1 | Message engine completion pulse |
| nmi_evt | input | 1 | Incoming NMI event (one cycle per event) |
| nmi_dis | input | 1 | External NMI disable |
| gbl_smi_en | input | 1 | External global SMI enable |
| tmr_halt | output | 1 | Stops the watchdog counter and event messages |
| send_req | output | 1 | Request to the message engine |
| tmr_en_wr_ok | output | 1 | Write gate for the external watchdog-enable bit |
| nmi_out | output | 1 | NMI pulse |
| smi_out | output | 1 | SMI pulse |

## Verification
NMI routing is tried with redirect off and then with redirect on. With redirect on, every pairing of the disable input and the global enable is applied, so a gating term that was dropped or inverted changes which output pulses. The forced-NMI bit receives a set, a write of zero, and a second one, which tells a toggle apart from a level bit and a repeated pulse apart from a single one. The send bit receives a completion alone, a completion that collides with a write, and rewrites while set, which exposes any wrong priority. The lock receives a zero write, a write of other fields, and a reset, which shows that only reset clears it.

// File: rtl/wnc_pkg.sv
package wnc_pkg;
  localparam int unsigned WNC_W  = 16;
  localparam int unsigned LOCK_B = 12;
  localparam int unsigned HALT_B = 11;
  localparam int unsigned SEND_B = 10;
  localparam int unsigned REDIR_B = 9;
  localparam int unsigned FNMI_B = 8;

  typedef struct packed {
    logic lock;
    logic halt;
    logic send;
    logic redir;
    logic fnmi;
  } wnc_bits_t;
endpackage

// File: rtl/wnc_ctl_regs.sv
module wnc_ctl_regs
  import wnc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  wnc_bits_t wr_bits,
  input  logic      send_done,
  output wnc_bits_t state,
  output logic      force_set
);
  wnc_bits_t st_q;

  assign force_set = wr_en && wr_bits.fnmi && !st_q.fnmi;
  assign state     = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (wr_en && wr_bits.lock) st_q.lock <= 1'b1;
      if (wr_en) begin
        st_q.halt  <= wr_bits.halt;
        st_q.redir <= wr_bits.redir;
      end
      if (send_done)                                st_q.send <= 1'b0;
      else if (wr_en && wr_bits.send && !st_q.send) st_q.send <= 1'b1;
      if (wr_en && wr_bits.fnmi) st_q.fnmi <= !st_q.fnmi;
    end
  end

  // R3: lock sticks until reset
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    st_q.lock |=> st_q.lock);
  // R7: completion always clears the request
  a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
    send_done |=> !st_q.send);
  // R6: an uncontested write of one sets the request
  a_r6_send_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bits.send && !send_done) |=> st_q.send);
  // R10: second write of one acknowledges
  a_r10_force_ack: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bits.fnmi && st_q.fnmi) |=> !st_q.fnmi);
  // R10: no write of one leaves the bit alone
  a_r10_write0_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_bits.fnmi) |=> $stable(st_q.fnmi));
endmodule

// File: rtl/wnc_nmi_route.sv
module wnc_nmi_route (
  input  logic clk,
  input  logic rst,
  input  logic nmi_evt,
  input  logic nmi_dis,
  input  logic gbl_smi_en,
  input  logic redir,
  input  logic force_set,
  output logic nmi_out,
  output logic smi_out
);
  logic smi_gate;
  assign smi_gate = !nmi_dis && gbl_smi_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_out <= 1'b0;
      smi_out <= 1'b0;
    end else begin
      nmi_out <= force_set || (nmi_evt && !redir);
      smi_out <= nmi_evt && redir && smi_gate;
    end
  end

  // R8: event passes to NMI when not redirected
  a_r8_pass_nmi: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && !redir) |=> nmi_out);
  // R9: gated-off redirection produces no SMI
  a_r9_smi_blocked: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && redir && (nmi_dis || !gbl_smi_en)) |=> !smi_out);
  // R9: an SMI only ever follows a redirected event
  a_r9_smi_source: assert property (@(posedge clk) disable iff (rst)
    smi_out |-> $past(nmi_evt && redir));
endmodule

// File: rtl/wdt_nmi_ctl.sv
module wdt_nmi_ctl
  import wnc_pkg::*;
#(
  parameter int unsigned W = WNC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         send_done,
  input  logic         nmi_evt,
  input  logic         nmi_dis,
  input  logic         gbl_smi_en,
  output logic         tmr_halt,
  output logic         send_req,
  output logic         tmr_en_wr_ok,
  output logic         nmi_out,
  output logic         smi_out
);
  wnc_bits_t wr_bits;
  wnc_bits_t state;
  logic      force_set;
  logic      unused_wbits;

  assign wr_bits.lock  = wdata[LOCK_B];
  assign wr_bits.halt  = wdata[HALT_B];
  assign wr_bits.send  = wdata[SEND_B];
  assign wr_bits.redir = wdata[REDIR_B];
  assign wr_bits.fnmi  = wdata[FNMI_B];
  assign unused_wbits  = ^{wdata[W-1:LOCK_B+1], wdata[FNMI_B-1:0]};

  wnc_ctl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_bits   (wr_bits),
    .send_done (send_done),
    .state     (state),
    .force_set (force_set)
  );

  wnc_nmi_route u_route (
    .clk        (clk),
    .rst        (rst),
    .nmi_evt    (nmi_evt),
    .nmi_dis    (nmi_dis),
    .gbl_smi_en (gbl_smi_en),
    .redir      (state.redir),
    .force_set  (force_set),
    .nmi_out    (nmi_out),
    .smi_out    (smi_out)
  );

  always_comb begin
    rdata          = '0;
    rdata[LOCK_B]  = state.lock;
    rdata[HALT_B]  = state.halt;
    rdata[SEND_B]  = state.send;
    rdata[REDIR_B] = state.redir;
    rdata[FNMI_B]  = state.fnmi;
  end

  assign tmr_halt     = state.halt;
  assign send_req     = state.send;
  assign tmr_en_wr_ok = !state.lock;

  // R4: gate closed whenever lock reads back as set
  a_r4_gate_closed: assert property (@(posedge clk) disable iff (rst)
    rdata[LOCK_B] |-> !tmr_en_wr_ok);
  // R9: NMI and SMI never fire together from routing
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    (nmi_out && smi_out) |-> $past(force_set));
endmodule

// File: tb/wdt_nmi_ctl_tb.sv
module wdt_nmi_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        send_done = 1'b0, nmi_evt = 1'b0, nmi_dis = 1'b0, gbl_smi_en = 1'b0;
  logic        tmr_halt, send_req, tmr_en_wr_ok, nmi_out, smi_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_nmi_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .send_done(send_done), .nmi_evt(nmi_evt), .nmi_dis(nmi_dis),
    .gbl_smi_en(gbl_smi_en), .tmr_halt(tmr_halt), .send_req(send_req),
    .tmr_en_wr_ok(tmr_en_wr_ok), .nmi_out(nmi_out), .smi_out(smi_out)
  );

  typedef struct {
    string       tag;
    logic [20:0] exp;
  } item_t;
  item_t sb_q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  // reference state
  bit m_lock, m_halt, m_send, m_redir, m_fnmi;

  function automatic logic [15:0] img();
    logic [15:0] v = '0;
    v[12] = m_lock; v[11] = m_halt; v[10] = m_send; v[9] = m_redir; v[8] = m_fnmi;
    return v;
  endfunction

  // monitor: pops and compares on the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [20:0] act;
      it  = sb_q.pop_front();
      act = {rdata, tmr_halt, send_req, tmr_en_wr_ok, nmi_out, smi_out};
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input bit w, input logic [15:0] d, input bit evt,
                     input bit dis, input bit gbl, input bit dn, input string tag);
    bit e_nmi, e_smi;
    item_t it;
    wr_en = w; wdata = d; nmi_evt = evt; nmi_dis = dis; gbl_smi_en = gbl; send_done = dn;
    e_nmi = (w && d[8] && !m_fnmi) || (evt && !m_redir);
    e_smi = evt && m_redir && !dis && gbl;
    if (w && d[12]) m_lock = 1'b1;
    if (w) begin m_halt = d[11]; m_redir = d[9]; end
    if (dn) m_send = 1'b0;
    else if (w && d[10]) m_send = 1'b1;
    if (w && d[8]) m_fnmi = !m_fnmi;
    @(posedge clk);
    #1;
    it.tag = tag;
    it.exp = {img(), m_halt, m_send, !m_lock, e_nmi, e_smi};
    sb_q.push_back(it);
    @(negedge clk);
    wr_en = 1'b0; nmi_evt = 1'b0; send_done = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    item_t it;
    rst = 1'b1;
    @(posedge clk);
    #1;
    {m_lock, m_halt, m_send, m_redir, m_fnmi} = '0;
    it.tag = tag;
    it.exp = {16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    sb_q.push_back(it);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    {m_lock, m_halt, m_send, m_redir, m_fnmi} = '0;
    repeat (2) @(posedge clk);
    do_reset("R1 reset state");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R1 idle after reset");
    cyc(1, 16'hE0FF, 0, 0, 0, 0, "R2 reserved bits ignored");
    cyc(1, 16'h0800, 0, 0, 0, 0, "R5 halt set");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R5 halt cleared");
    cyc(0, 16'h0000, 1, 0, 1, 0, "R8 event to NMI");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R8 pulse one cycle");
    cyc(1, 16'h0200, 0, 0, 0, 0, "R8 redirect set");
    cyc(0, 16'h0000, 1, 0, 1, 0, "R9 redirected SMI");
    cyc(0, 16'h0000, 1, 1, 1, 0, "R9 blocked by nmi_dis");
    cyc(0, 16'h0000, 1, 0, 0, 0, "R9 blocked by global enable");
    cyc(0, 16'h0000, 1, 1, 0, 0, "R9 blocked by both");
    cyc(1, 16'h0000, 1, 0, 1, 0, "R8 redirect cleared");
    cyc(1, 16'h0100, 0, 0, 0, 0, "R10 forced NMI set");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R10 single pulse");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R10 write zero no effect");
    cyc(1, 16'h0100, 0, 0, 0, 0, "R10 acknowledge no pulse");
    cyc(1, 16'h0400, 0, 0, 0, 0, "R6 send request");
    cyc(1, 16'h0400, 0, 0, 0, 0, "R7 rewrite while set");
    cyc(1, 16'h0400, 0, 0, 0, 1, "R7 done wins over write");
    cyc(1, 16'h0400, 0, 0, 0, 1, "R7 done with write while clear");
    cyc(1, 16'h0400, 0, 0, 0, 0, "R6 send request again");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R7 write zero ignored");
    cyc(0, 16'h0000, 0, 0, 0, 1, "R7 done clears");
    cyc(1, 16'h1000, 0, 0, 0, 0, "R3 R4 lock set gate closed");
    cyc(1, 16'h0000, 0, 0, 0, 0, "R3 write zero keeps lock");
    cyc(1, 16'h0B00, 0, 0, 0, 0, "R11 combined image");
    do_reset("R3 reset clears lock");
    cyc(0, 16'h0000, 0, 0, 0, 0, "R4 gate open after reset");
    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule